// File: doc/BRIEF.md
# Traffic Light Phase Controller

This block sequences a single set of signal lamps through three colour phases: red, then green, then yellow, then back to red. Red and green are held until a one-cycle advance request arrives. Yellow is timed internally: on entry, a counter starts from zero, and the phase ends on its own after a fixed number of clock cycles. While yellow is timing, any advance request is ignored.

The controller is a registered Mealy machine. One clocked process computes the next phase from the current phase, the advance request and the timer. In the same clock edge it loads the lamp register with the one-hot pattern of that next phase. Every lamp output therefore comes straight from a flip-flop. Compared with a version that drives the lamps from combinational logic, the lamps change one cycle later, but each phase stays lit for the same number of cycles.

The number of colours and the yellow length are parameters. An active-low asynchronous reset forces the red phase at any time. The reset serves only for initialisation.

Top module: `traffic_lamp_ctrl`

## Requirements
- R1: While rst_ni is low, the lamp output shows red at once, without waiting for a clock edge. After reset is released, the controller starts in the red phase. The phase codes are red = 2'b00, yellow = 2'b01, green = 2'b10.
- R2: The lamp vector uses bit 0 for red, bit 1 for yellow and bit 2 for green. Exactly one bit is high in every cycle.
- R3: In red, a high adv_i at a rising clock edge moves the controller to green at that edge. With adv_i low, red holds.
- R4: In green, a high adv_i at a rising clock edge moves the controller to yellow at that edge. With adv_i low, green holds.
- R5: Yellow stays lit for exactly YEL_CYCLES clock cycles (default 10) and then changes to red with no request.
- R6: adv_i has no effect in yellow: the yellow length is the same whether adv_i is held high or low.
- R7: Lamp outputs are registered. A change on adv_i between clock edges does not change lamp_o before the next rising edge.
- R8: The yellow counter restarts from zero on every entry to yellow, so each yellow phase has the same length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Request to advance out of red or green |
| lamp_o | output | NUM_COLORS (3) | One-hot lamp drive: bit 0 red, bit 1 yellow, bit 2 green |

## Verification
The bench counts how many cycles yellow stays lit, on two separate passes. This catches an off-by-one in the terminal count, which would give a yellow one cycle too short or too long, and it catches a counter that is not cleared on entry, which would shorten the second pass. Holding adv_i high through yellow exposes a design that lets the request cut yellow short. Changing adv_i in the middle of a cycle shows whether the lamp is a real register or a combinational path from the input. Asserting reset in the middle of green, and sampling before any clock edge, shows whether the reset is really asynchronous.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  typedef enum logic [1:0] {
    PH_RED = 2'b00,
    PH_YEL = 2'b01,
    PH_GRN = 2'b10
  } phase_e;

  localparam int unsigned IDX_RED = 0;
  localparam int unsigned IDX_YEL = 1;
  localparam int unsigned IDX_GRN = 2;
endpackage

// File: rtl/tlc_yel_timer.sv
module tlc_yel_timer #(
  parameter int unsigned YEL_CYCLES = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = (YEL_CYCLES > 1) ? $clog2(YEL_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(YEL_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= '0;
    else if (run_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);                                                   // R5
  AST_LOAD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == '0));                                        // R8
  AST_CNT_STEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !done_o && !load_i) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R5
endmodule

// File: rtl/tlc_phase_fsm.sv
module tlc_phase_fsm
  import tlc_pkg::*;
#(
  parameter int unsigned NUM_COLORS = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  adv_i,
  input  logic                  yel_done_i,
  output logic                  yel_load_o,
  output logic                  yel_run_o,
  output logic [NUM_COLORS-1:0] lamp_o
);
  phase_e                state_q;
  logic [NUM_COLORS-1:0] lamp_q;

  function automatic logic [NUM_COLORS-1:0] lamp_of(phase_e ph);
    logic [NUM_COLORS-1:0] v;
    v = '0;
    case (ph)
      PH_YEL:  v[IDX_YEL] = 1'b1;
      PH_GRN:  v[IDX_GRN] = 1'b1;
      default: v[IDX_RED] = 1'b1;
    endcase
    return v;
  endfunction

  // Single clocked process: next phase and its lamp pattern load together.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_RED;
      lamp_q  <= lamp_of(PH_RED);
    end else begin
      case (state_q)
        PH_RED: if (adv_i) begin
          state_q <= PH_GRN;
          lamp_q  <= lamp_of(PH_GRN);
        end
        PH_GRN: if (adv_i) begin
          state_q <= PH_YEL;
          lamp_q  <= lamp_of(PH_YEL);
        end
        PH_YEL: if (yel_done_i) begin
          state_q <= PH_RED;
          lamp_q  <= lamp_of(PH_RED);
        end
        default: begin
          state_q <= PH_RED;
          lamp_q  <= lamp_of(PH_RED);
        end
      endcase
    end
  end

  assign yel_load_o = (state_q == PH_GRN) && adv_i;
  assign yel_run_o  = (state_q == PH_YEL);
  assign lamp_o     = lamp_q;

  AST_LAMP_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(lamp_q) == 1);                                          // R2
  AST_RED_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_RED && adv_i) |=> (state_q == PH_GRN));             // R3
  AST_GRN_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_GRN && adv_i) |=> (state_q == PH_YEL));             // R4
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != PH_YEL && !adv_i) |=> $stable(lamp_q));                // R7
  AST_YEL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_YEL && !yel_done_i) |=> (state_q == PH_YEL));       // R6
  AST_YEL_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_YEL && yel_done_i) |=> lamp_q[IDX_RED]);            // R5
endmodule

// File: rtl/traffic_lamp_ctrl.sv
module traffic_lamp_ctrl #(
  parameter int unsigned NUM_COLORS = 3,
  parameter int unsigned YEL_CYCLES = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  adv_i,
  output logic [NUM_COLORS-1:0] lamp_o
);
  logic yel_load, yel_run, yel_done;

  tlc_phase_fsm #(.NUM_COLORS(NUM_COLORS)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv_i),
    .yel_done_i (yel_done),
    .yel_load_o (yel_load),
    .yel_run_o  (yel_run),
    .lamp_o     (lamp_o)
  );

  tlc_yel_timer #(.YEL_CYCLES(YEL_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (yel_load),
    .run_i  (yel_run),
    .done_o (yel_done)
  );

  initial AST_THREE_COLORS: assert (NUM_COLORS == 3);                 // R2
endmodule

// File: tb/tb_traffic_lamp_ctrl.sv
module tb_traffic_lamp_ctrl;
  localparam int unsigned YEL = 10;
  localparam logic [2:0] L_RED = 3'b001, L_YEL = 3'b010, L_GRN = 3'b100;

  logic clk = 1'b0, rst_n = 1'b0, adv = 1'b0;
  logic [2:0] lamp;
  int errors = 0, checks = 0;

  traffic_lamp_ctrl #(.NUM_COLORS(3), .YEL_CYCLES(YEL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .adv_i(adv), .lamp_o(lamp));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: lamp=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 red in reset", lamp, L_RED);
    @(negedge clk); rst_n = 1'b1;
    step();
    chk("R1 red after release", lamp, L_RED);
  endtask

  task automatic t_red_hold_and_adv();
    adv = 1'b0;
    for (int i = 0; i < 5; i++) begin
      step();
      chk("R3 red holds", lamp, L_RED);
    end
    adv = 1'b1; step(); adv = 1'b0;
    chk("R3 red to green", lamp, L_GRN);
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R4 green holds", lamp, L_GRN);
    end
  endtask

  task automatic t_registered();
    #1 adv = 1'b1;
    #1 chk("R7 no change before edge", lamp, L_GRN);
    @(negedge clk);
    chk("R4 green to yellow", lamp, L_YEL);
  endtask

  // measures yellow length; lamp already yellow at entry
  task automatic count_yellow(input logic hold_adv, output int n);
    int ones_bad = 0;
    n = 1;
    adv = hold_adv;
    for (int i = 0; i < 3 * YEL; i++) begin
      step();
      if ($countones(lamp) != 1) ones_bad++;
      if (lamp == L_YEL) n++;
      else break;
    end
    adv = 1'b0;
    chk_int("R2 one lamp lit during yellow", ones_bad, 0);
  endtask

  task automatic t_yellow_first();
    int n;
    count_yellow(1'b1, n);
    chk_int("R5 R6 yellow length with adv held", n, YEL);
    chk("R5 yellow to red", lamp, L_RED);
  endtask

  task automatic t_yellow_second();
    int n;
    adv = 1'b1; step();
    chk("R3 second green", lamp, L_GRN);
    step(); adv = 1'b0;
    chk("R4 second yellow", lamp, L_YEL);
    count_yellow(1'b0, n);
    chk_int("R8 second yellow length", n, YEL);
    chk("R5 back to red", lamp, L_RED);
  endtask

  task automatic t_async_reset();
    adv = 1'b1; step(); adv = 1'b0;
    chk("R3 green before reset", lamp, L_GRN);
    #1 rst_n = 1'b0;
    #1 chk("R1 async red mid-cycle", lamp, L_RED);
    @(negedge clk); rst_n = 1'b1;
    step();
    chk("R1 red after second reset", lamp, L_RED);
    chk_int("R2 onehot after reset", $countones(lamp), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: timeout expired, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_red_hold_and_adv();
    t_registered();
    t_yellow_first();
    t_yellow_second();
    t_async_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule